// File: doc/BRIEF.md
# Temperature-to-Table Index Mapper

This block turns a signed whole-degree temperature reading into two table indices. The first index selects one of 48 byte slots of a calibration lookup table. The second index selects one of 8 slots of a companion offset table. The lookup mapping is piecewise. Below a lower limit, every reading shares a single slot. Between the lower limit and a knee, each slot covers four degrees. Above the knee, each slot covers two degrees, so the table has finer resolution where the calibrated quantity changes fastest. The offset mapping uses two short edge slots near zero and then steps in sixteen-degree bands.

One mode bit selects who owns the indices. In automatic mode, each valid temperature strobe recomputes both indices. In host mode, strobes are ignored and the host writes the lookup index directly through a small register write port. A surrounding bus decoder presents that port. The chip then addresses the calibration memory with the index it holds.

Top module: `temp_index_mapper`

## Requirements
- R1: After a synchronous reset, the mode is automatic (`auto_en` = 1) and both `lut_idx` and `ofs_idx` are 0.
- R2: In automatic mode, a strobed temperature below -36 gives `lut_idx` 0.
- R3: In automatic mode, a strobed temperature t with -36 <= t <= 55 gives `lut_idx` = 1 + floor((t + 36) / 4). So -36 gives 1 and 52 gives 23.
- R4: In automatic mode, a strobed temperature t >= 56 gives `lut_idx` = min(47, 24 + floor((t - 56) / 2)). So 56 gives 24, 102 gives 47, and anything higher stays at 47.
- R5: In automatic mode, a strobed temperature gives `ofs_idx` equal to the number of breakpoints in {-8, 8, 24, 40, 56, 72, 88} that are less than or equal to t. The range is 0 to 7.
- R6: Both indices change on the clock edge at which `temp_vld` is sampled high, and are visible from that edge on. Without a strobe, they hold their values.
- R7: A write with `wr_sel` = 0 loads `wr_data[0]` into the mode bit (1 = automatic, 0 = host), effective from the next edge.
- R8: In host mode, temperature strobes change neither index.
- R9: In host mode, a write with `wr_sel` = 1 loads `wr_data` into `lut_idx` at the next edge. Values above 47 are clamped to 47, and `ofs_idx` is left unchanged.
- R10: In automatic mode, a write with `wr_sel` = 1 leaves `lut_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_vld | input | 1 | Strobe marking a new temperature sample |
| temp | input | 8 | Signed temperature in whole degrees |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | Register select: 0 selects the mode register, 1 selects the index register |
| wr_data | input | 8 | Write data |
| auto_en | output | 1 | Current mode (1 = automatic) |
| lut_idx | output | 6 | Lookup table index, 0 to 47 |
| ofs_idx | output | 3 | Offset table index, 0 to 7 |

## Verification
The assertions assume that a mode write and a temperature strobe never fall in the same cycle. They also assume that an index write never shares a cycle with a strobe. Under those conditions the stability properties can attribute every index change to exactly one cause. The scoreboard driver keeps this by issuing at most one kind of operation per clock. The `temp` input is read only when strobed, so the driver changes it freely in idle cycles, and the hold checks show that those changes are ignored.

// File: rtl/tim_pkg.sv
package tim_pkg;

    localparam int TEMP_W     = 8;
    localparam int DATA_W     = 8;
    localparam int LUT_DEPTH  = 48;
    localparam int OFS_DEPTH  = 8;
    localparam int LUT_IW     = $clog2(LUT_DEPTH);
    localparam int OFS_IW     = $clog2(OFS_DEPTH);
    localparam int LUT_LAST   = LUT_DEPTH - 1;
    localparam int OFS_LAST   = OFS_DEPTH - 1;

    // Lookup breakpoints (degrees) and step sizes
    localparam int LUT_FLOOR_T = -36;
    localparam int LUT_KNEE_T  = 56;
    localparam int COARSE_STEP = 4;
    localparam int FINE_STEP   = 2;

    // Offset breakpoints
    localparam int OFS_EDGE0_T = -8;
    localparam int OFS_EDGE1_T = 8;
    localparam int OFS_STEP    = 16;

    typedef logic [LUT_IW-1:0] lut_idx_t;
    typedef logic [OFS_IW-1:0] ofs_idx_t;
    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        lut_idx_t lut;
        ofs_idx_t ofs;
    } idx_pair_t;

    typedef enum logic {
        MODE_HOST = 1'b0,
        MODE_AUTO = 1'b1
    } mode_e;

    typedef enum logic {
        SEL_MODE  = 1'b0,
        SEL_INDEX = 1'b1
    } reg_sel_e;

    // Saturate an integer into [0, last]
    function automatic int sat_range(input int v, input int last);
        if (v < 0)         return 0;
        else if (v > last) return last;
        else               return v;
    endfunction

endpackage

// File: rtl/tim_lut_map.sv
module tim_lut_map
    import tim_pkg::*;
#(
    parameter int FLOOR_T = LUT_FLOOR_T,
    parameter int KNEE_T  = LUT_KNEE_T,
    parameter int COARSE  = COARSE_STEP,
    parameter int FINE    = FINE_STEP
) (
    input  temp_t    temp,
    output lut_idx_t idx
);
    localparam int COARSE_SLOTS = (KNEE_T - FLOOR_T) / COARSE;
    localparam int FINE_BASE    = 1 + COARSE_SLOTS;

    always_comb begin
        int t;
        int v;
        t = int'(temp);
        if (t < FLOOR_T)
            v = 0;
        else if (t < KNEE_T)
            v = 1 + (t - FLOOR_T) / COARSE;
        else
            v = FINE_BASE + (t - KNEE_T) / FINE;
        idx = lut_idx_t'(sat_range(v, LUT_LAST));
    end
endmodule

// File: rtl/tim_ofs_map.sv
module tim_ofs_map
    import tim_pkg::*;
#(
    parameter int EDGE0_T = OFS_EDGE0_T,
    parameter int EDGE1_T = OFS_EDGE1_T,
    parameter int STEP    = OFS_STEP
) (
    input  temp_t    temp,
    output ofs_idx_t idx
);
    always_comb begin
        int t;
        int v;
        t = int'(temp);
        if (t < EDGE0_T)
            v = 0;
        else if (t < EDGE1_T)
            v = 1;
        else
            v = 2 + (t - EDGE1_T) / STEP;
        idx = ofs_idx_t'(sat_range(v, OFS_LAST));
    end
endmodule

// File: rtl/tim_ctrl.sv
module tim_ctrl
    import tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output mode_e             mode,
    output logic              idx_wr,
    output logic [DATA_W-1:0] idx_data
);
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_AUTO;
        else if (wr_en && wr_sel == SEL_MODE)
            mode_q <= mode_e'(wr_data[0]);
    end

    assign mode     = mode_q;
    assign idx_wr   = wr_en && (wr_sel == SEL_INDEX);
    assign idx_data = wr_data;

    // R7: mode only moves on a mode-register write
    p_mode_only_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_MODE) |=> $stable(mode_q));

    // R7: written bit lands in the mode register
    p_mode_loads_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_MODE) |=> (mode_q == mode_e'($past(wr_data[0]))));
endmodule

// File: rtl/tim_index_reg.sv
module tim_index_reg
    import tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              temp_vld,
    input  idx_pair_t         mapped,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] idx_data,
    output idx_pair_t         idx
);
    idx_pair_t idx_q;
    lut_idx_t  host_lut;

    always_comb begin
        if (int'(idx_data) > LUT_LAST)
            host_lut = lut_idx_t'(LUT_LAST);
        else
            host_lut = lut_idx_t'(idx_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (mode == MODE_AUTO) begin
            if (temp_vld)
                idx_q <= mapped;
        end else if (idx_wr) begin
            idx_q.lut <= host_lut;
        end
    end

    assign idx = idx_q;

    // R6: no strobe in automatic mode keeps both indices
    p_auto_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AUTO && !temp_vld) |=> ($stable(idx_q.lut) && $stable(idx_q.ofs)));

    // R8: host mode without an index write freezes both indices
    p_host_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOST && !idx_wr) |=> ($stable(idx_q.lut) && $stable(idx_q.ofs)));

    // R9: in-range host write lands verbatim
    p_host_write_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOST && idx_wr && int'(idx_data) <= LUT_LAST)
        |=> (int'(idx_q.lut) == int'($past(idx_data))));

    // R9: out-of-range host write clamps to last slot, offset untouched
    p_host_clamp_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOST && idx_wr && int'(idx_data) > LUT_LAST)
        |=> (int'(idx_q.lut) == LUT_LAST && $stable(idx_q.ofs)));

    // R10: index write in automatic mode has no effect
    p_auto_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AUTO && idx_wr && !temp_vld) |=> $stable(idx_q.lut));

    // R4: lookup index never leaves the table
    p_lut_bound_r4: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q.lut) <= LUT_LAST);

    // R5: offset index never leaves the table
    p_ofs_bound_r5: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q.ofs) <= OFS_LAST);
endmodule

// File: rtl/temp_index_mapper.sv
module temp_index_mapper
    import tim_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     temp_vld,
    input  logic signed [TEMP_W-1:0] temp,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     auto_en,
    output logic [LUT_IW-1:0]        lut_idx,
    output logic [OFS_IW-1:0]        ofs_idx
);
    mode_e             mode;
    logic              idx_wr;
    logic [DATA_W-1:0] idx_data;
    idx_pair_t         mapped;
    idx_pair_t         idx;

    tim_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (reg_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .mode     (mode),
        .idx_wr   (idx_wr),
        .idx_data (idx_data)
    );

    tim_lut_map u_lut_map (
        .temp (temp),
        .idx  (mapped.lut)
    );

    tim_ofs_map u_ofs_map (
        .temp (temp),
        .idx  (mapped.ofs)
    );

    tim_index_reg u_index (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .temp_vld (temp_vld),
        .mapped   (mapped),
        .idx_wr   (idx_wr),
        .idx_data (idx_data),
        .idx      (idx)
    );

    assign auto_en = (mode == MODE_AUTO);
    assign lut_idx = idx.lut;
    assign ofs_idx = idx.ofs;
endmodule

// File: tb/temp_index_mapper_test.sv
`timescale 1ns/1ps
module temp_index_mapper_test;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              temp_vld = 1'b0;
    logic signed [7:0] temp = '0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              auto_en;
    logic [5:0]        lut_idx;
    logic [2:0]        ofs_idx;

    always #2.5 clk = ~clk;

    temp_index_mapper uut (
        .clk(clk), .rst(rst), .temp_vld(temp_vld), .temp(temp),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .auto_en(auto_en), .lut_idx(lut_idx), .ofs_idx(ofs_idx)
    );

    typedef struct {
        int    lut;
        int    ofs;
        int    aut;
        string req;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   m_lut = 0;
    int   m_ofs = 0;
    int   m_aut = 1;
    bit   done  = 0;

    function automatic int ref_lut(input int t);
        int v;
        if (t < -36)      v = 0;
        else if (t <= 55) v = 1 + (t + 36) / 4;
        else              v = 24 + (t - 56) / 2;
        if (v > 47) v = 47;
        return v;
    endfunction

    function automatic int ref_ofs(input int t);
        int bps[7] = '{-8, 8, 24, 40, 56, 72, 88};
        int c = 0;
        foreach (bps[i]) if (t >= bps[i]) c++;
        return c;
    endfunction

    // Driver: one operation per clock, expected result queued after the edge
    task automatic step(input bit vld, input int t, input bit we,
                        input bit sel, input int d, input string req);
        @(negedge clk);
        temp_vld = vld;
        temp     = 8'(t);
        wr_en    = we;
        wr_sel   = sel;
        wr_data  = 8'(d);
        if (vld && m_aut == 1) begin
            m_lut = ref_lut(t);
            m_ofs = ref_ofs(t);
        end
        if (we && !sel)
            m_aut = d & 1;
        else if (we && sel && m_aut == 0)
            m_lut = (d > 47) ? 47 : d;
        @(posedge clk);
        sb.push_back('{m_lut, m_ofs, m_aut, req});
    endtask

    // Monitor: compare at the falling edge after each queued edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (int'(lut_idx) != e.lut || int'(ofs_idx) != e.ofs
                    || int'(auto_en) != e.aut) begin
                    n_bad++;
                    $display("FAIL %s: got lut=%0d ofs=%0d auto=%0d, expected lut=%0d ofs=%0d auto=%0d",
                             e.req, lut_idx, ofs_idx, auto_en, e.lut, e.ofs, e.aut);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        sb.push_back('{0, 0, 1, "R1 reset state"});
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: full sweep in automatic mode
        for (int t = -128; t <= 127; t++) begin
            if (t < -36)      step(1, t, 0, 0, 0, "R2/R5/R6 below floor");
            else if (t <= 55) step(1, t, 0, 0, 0, "R3/R5/R6 coarse band");
            else              step(1, t, 0, 0, 0, "R4/R5/R6 fine band");
        end
        // Spot corners
        step(1, -37, 0, 0, 0, "R2 just below floor");
        step(1, -36, 0, 0, 0, "R3 floor maps to 1");
        step(1, 52,  0, 0, 0, "R3 top coarse maps to 23");
        step(1, 56,  0, 0, 0, "R4 knee maps to 24");
        step(1, 102, 0, 0, 0, "R4 last slot 47");
        step(1, 127, 0, 0, 0, "R4 saturation");
        step(1, 87,  0, 0, 0, "R5 just below last offset");

        // R6: idle cycles with a moving temperature keep the indices
        step(0, -100, 0, 0, 0, "R6 hold without strobe");
        step(0, 10,   0, 0, 0, "R6 hold without strobe");

        // R10: index write ignored in automatic mode
        step(0, 0, 1, 1, 5,  "R10 auto ignores index write");
        step(0, 0, 1, 1, 30, "R10 auto ignores index write");

        // R7: switch to host mode
        step(0, 0, 1, 0, 0, "R7 enter host mode");

        // R8: strobes ignored in host mode
        step(1, -100, 0, 0, 0, "R8 host ignores strobe");
        step(1, 60,   0, 0, 0, "R8 host ignores strobe");

        // R9: host index writes, including clamping
        step(0, 0, 1, 1, 30,  "R9 host write 30");
        step(0, 0, 1, 1, 0,   "R9 host write 0");
        step(0, 0, 1, 1, 47,  "R9 host write 47");
        step(0, 0, 1, 1, 200, "R9 host write clamps");
        step(0, 0, 1, 1, 48,  "R9 host write clamps");
        step(0, 0, 0, 0, 0,   "R8 host idle hold");

        // R7: back to automatic, strobes effective again
        step(0, 0, 1, 0, 1, "R7 re-enter auto mode");
        step(1, -40, 0, 0, 0, "R2 after return to auto");
        step(1, 20,  0, 0, 0, "R3 after return to auto");

        step(0, 0, 0, 0, 0, "R6 final idle");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule